// File: doc/BRIEF.md
# Indirect Configuration Window Port

This block is a register slave on a local processor bus. Through it the processor can issue configuration reads and writes to devices on a downstream link. Software first loads a target address into an ordinary address register. It then touches a data window. Each access to the window launches one configuration transaction on the link, aimed at whatever the address register holds at that moment.

The window stores nothing. For a write, the bus write data is handed to the outbound request queue in the same cycle the push is offered. For a read, the local bus is held in a wait state until the completion for that transaction is popped from the inbound completion queue. The completion payload then drives the read data for that single cycle.

Only one transaction may be in flight at a time. Each request carries a rolling tag, and completions carrying any other tag are popped and discarded. A failed completion makes a read return all ones and sets a sticky error bit, which software clears by writing one to it. A separate link-side read port gives a read-only view of the block. On that view the data window is always zero.

Top module: `cfg_window_port`

## Requirements
- R1: After reset the address register reads 0, the status register reads 0, and neither rq_valid nor cq_pop is asserted.
- R2: The address register at local offset 0x32C is a plain 32-bit read/write register. An access to it completes in its own cycle and never raises rq_valid.
- R3: A local write to the data window at offset 0x330 offers a push with rq_write=1, rq_addr equal to the address register, and rq_data equal to lb_wdata. lb_ready is high in the same cycle that rq_ready accepts the push, which releases the bus.
- R4: While rq_ready stays low, a data-window access keeps rq_valid high with stable address and tag, and keeps lb_ready low.
- R5: A local read of the data window offers a push with rq_write=0. The bus is held with lb_ready low until a completion with the request's tag is seen. In that cycle lb_ready is high and lb_rdata equals cq_data.
- R6: While a transaction waits, every valid completion is popped (cq_pop=1). A completion whose tag differs from the outstanding request is dropped and does not end the transaction.
- R7: At most one transaction is outstanding. After a write's push has been accepted, a new data-window access is not offered until the write's completion has been popped.
- R8: A completion with cq_ok=0 sets the sticky error bit, which is bit 0 of the status register at offset 0x334. If that completion answers a read, lb_rdata is all ones. Writing 1 to bit 0 clears the error bit; writing 0 leaves it unchanged.
- R9: On the link-side read port, offset 0x32C returns the address register, and every other offset returns 0. The data window offset 0x330 and the status offset both return 0.
- R10: Request tags start at 0 after reset and advance by one per completed transaction, wrapping modulo 2^TAG_W (16 by default).
- R11: A local read of an unmapped offset completes in the same cycle and returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lb_sel | input | 1 | Local bus access request, held until lb_ready |
| lb_wr | input | 1 | 1 = write, 0 = read |
| lb_addr | input | ADDR_W | Local byte offset |
| lb_wdata | input | DATA_W | Local write data |
| lb_ready | output | 1 | Access completes in this cycle |
| lb_rdata | output | DATA_W | Local read data, valid with lb_ready |
| rq_valid | output | 1 | Request push offered |
| rq_ready | input | 1 | Request queue accepts the push |
| rq_write | output | 1 | 1 = configuration write, 0 = read |
| rq_addr | output | DATA_W | Configuration target address |
| rq_data | output | DATA_W | Configuration write data |
| rq_tag | output | TAG_W | Request tag |
| cq_valid | input | 1 | Completion available at queue head |
| cq_pop | output | 1 | Pop the completion queue head |
| cq_tag | input | TAG_W | Completion tag |
| cq_ok | input | 1 | Completion success status |
| cq_data | input | DATA_W | Completion read data |
| lk_addr | input | ADDR_W | Link-side read offset |
| lk_rdata | output | DATA_W | Link-side read data |

## Verification
A vector table alternates address loads, window writes and window reads. The rows vary push stalls of zero, one and two cycles, completions preceded or not by a completion with the wrong tag, and successful or failing status. These rows separate a design that samples the address too early or late, releases the bus on the wrong cycle, or accepts a stray completion. A directed overlap test starts a read while a write is still waiting for its completion. This shows whether the write's completion is wrongly taken as the read's answer. A run of back-to-back writes wraps the tag counter. Checks of the error clear, the link view, an unmapped offset and a mid-run reset complete the coverage.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

   localparam int ERR_BIT = 0;
endpackage

// File: rtl/cfgp_regs.sv
module cfgp_regs #(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter logic [11:0] CADDR_OFF = 12'h32C,
   parameter logic [11:0] STAT_OFF  = 12'h334
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lb_sel,
   input  logic              lb_wr,
   input  logic [ADDR_W-1:0] lb_addr,
   input  logic [DATA_W-1:0] lb_wdata,
   input  logic              err_set,
   output logic [DATA_W-1:0] addr_q,
   output logic              err_q,
   output logic [DATA_W-1:0] rd_val
);
   import cfgp_pkg::*;

   localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(CADDR_OFF);
   localparam logic [ADDR_W-1:0] S_OFF = ADDR_W'(STAT_OFF);

   logic hit_addr, hit_stat;

   assign hit_addr = lb_sel && (lb_addr == A_OFF);
   assign hit_stat = lb_sel && (lb_addr == S_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (hit_addr && lb_wr) begin
         addr_q <= lb_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (err_set) begin
         err_q <= 1'b1;
      end else if (hit_stat && lb_wr && lb_wdata[ERR_BIT]) begin
         err_q <= 1'b0;
      end
   end

   always_comb begin
      rd_val = '0;
      if (hit_addr) begin
         rd_val = addr_q;
      end else if (hit_stat) begin
         rd_val[ERR_BIT] = err_q;
      end
   end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [DATA_W-1:0] addr_q,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic              rq_write,
   output logic [DATA_W-1:0] rq_addr,
   output logic [DATA_W-1:0] rq_data,
   output logic [TAG_W-1:0]  rq_tag,
   input  logic              cq_valid,
   output logic              cq_pop,
   input  logic [TAG_W-1:0]  cq_tag,
   input  logic              cq_ok,
   input  logic [DATA_W-1:0] cq_data,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              err_set
);
   import cfgp_pkg::*;

   seq_state_e       state_q;
   logic             pend_rd_q;
   logic [TAG_W-1:0] tag_q;
   logic             accept, waiting, match;

   assign waiting  = (state_q == SEQ_WAIT);
   assign rq_valid = !waiting && acc;
   assign rq_write = acc_wr;
   assign rq_addr  = addr_q;
   assign rq_data  = acc_wdata;
   assign rq_tag   = tag_q;
   assign accept   = rq_valid && rq_ready;

   assign cq_pop   = waiting && cq_valid;
   assign match    = cq_pop && (cq_tag == tag_q);

   assign done     = (accept && acc_wr) || (match && pend_rd_q);
   assign rdata    = cq_ok ? cq_data : '1;
   assign err_set  = match && !cq_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         pend_rd_q <= 1'b0;
         tag_q     <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: if (accept) begin
               state_q   <= SEQ_WAIT;
               pend_rd_q <= !acc_wr;
            end
            SEQ_WAIT: if (match) begin
               state_q   <= SEQ_IDLE;
               pend_rd_q <= 1'b0;
               tag_q     <= tag_q + 1'b1;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfgp_link_view.sv
module cfgp_link_view #(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter logic [11:0] CADDR_OFF = 12'h32C,
   parameter bit          SHOW_ADDR = 1'b1
) (
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] lk_rdata
);
   localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(CADDR_OFF);

   generate
      if (SHOW_ADDR) begin : g_show
         assign lk_rdata = (lk_addr == A_OFF) ? addr_q : '0;
      end else begin : g_hide
         logic unused_view;
         assign unused_view = ^{lk_addr, addr_q};
         assign lk_rdata    = '0;
      end
   endgenerate
endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port #(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter int          TAG_W     = 4,
   parameter logic [11:0] CADDR_OFF = 12'h32C,
   parameter logic [11:0] DATA_OFF  = 12'h330,
   parameter logic [11:0] STAT_OFF  = 12'h334,
   parameter bit          LINK_SHOW_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lb_sel,
   input  logic              lb_wr,
   input  logic [ADDR_W-1:0] lb_addr,
   input  logic [DATA_W-1:0] lb_wdata,
   output logic              lb_ready,
   output logic [DATA_W-1:0] lb_rdata,
   output logic              rq_valid,
   input  logic              rq_ready,
   output logic              rq_write,
   output logic [DATA_W-1:0] rq_addr,
   output logic [DATA_W-1:0] rq_data,
   output logic [TAG_W-1:0]  rq_tag,
   input  logic              cq_valid,
   output logic              cq_pop,
   input  logic [TAG_W-1:0]  cq_tag,
   input  logic              cq_ok,
   input  logic [DATA_W-1:0] cq_data,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic [DATA_W-1:0] lk_rdata
);
   localparam logic [ADDR_W-1:0] D_OFF = ADDR_W'(DATA_OFF);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("cfg_window_port: DATA_W must be at least 8");
      end
      if (TAG_W < 1 || TAG_W > 16) begin : g_bad_tag
         $error("cfg_window_port: TAG_W must be 1..16");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("cfg_window_port: ADDR_W must cover the register offsets");
      end
      if (CADDR_OFF == DATA_OFF || CADDR_OFF == STAT_OFF || DATA_OFF == STAT_OFF) begin : g_bad_map
         $error("cfg_window_port: register offsets must be distinct");
      end
   endgenerate

   logic              data_hit;
   logic [DATA_W-1:0] addr_q, reg_rd, seq_rdata;
   logic              err_q, err_set, seq_done;

   assign data_hit = lb_sel && (lb_addr == D_OFF);

   cfgp_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CADDR_OFF(CADDR_OFF), .STAT_OFF(STAT_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .lb_sel(lb_sel), .lb_wr(lb_wr), .lb_addr(lb_addr), .lb_wdata(lb_wdata),
      .err_set(err_set), .addr_q(addr_q), .err_q(err_q), .rd_val(reg_rd)
   );

   cfgp_seq #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .acc(data_hit), .acc_wr(lb_wr), .acc_wdata(lb_wdata), .addr_q(addr_q),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
      .rq_addr(rq_addr), .rq_data(rq_data), .rq_tag(rq_tag),
      .cq_valid(cq_valid), .cq_pop(cq_pop), .cq_tag(cq_tag), .cq_ok(cq_ok),
      .cq_data(cq_data), .done(seq_done), .rdata(seq_rdata), .err_set(err_set)
   );

   cfgp_link_view #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CADDR_OFF(CADDR_OFF), .SHOW_ADDR(LINK_SHOW_ADDR)
   ) u_link (
      .lk_addr(lk_addr), .addr_q(addr_q), .lk_rdata(lk_rdata)
   );

   logic unused_err;
   assign unused_err = err_q;

   assign lb_ready = lb_sel && (data_hit ? seq_done : 1'b1);
   assign lb_rdata = data_hit ? seq_rdata : reg_rd;
endmodule

// File: rtl/cfg_window_port_chk.sv
module cfg_window_port_chk #(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 32,
   parameter int          TAG_W    = 4,
   parameter logic [11:0] DATA_OFF = 12'h330
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lb_sel,
   input logic              lb_wr,
   input logic [ADDR_W-1:0] lb_addr,
   input logic              lb_ready,
   input logic [DATA_W-1:0] lb_rdata,
   input logic              rq_valid,
   input logic              rq_ready,
   input logic [DATA_W-1:0] rq_addr,
   input logic [TAG_W-1:0]  rq_tag,
   input logic              cq_valid,
   input logic              cq_pop,
   input logic [TAG_W-1:0]  cq_tag,
   input logic              cq_ok,
   input logic [DATA_W-1:0] cq_data,
   input logic [ADDR_W-1:0] lk_addr,
   input logic [DATA_W-1:0] lk_rdata
);
   localparam logic [ADDR_W-1:0] D_OFF = ADDR_W'(DATA_OFF);

   logic             busy_q, rd_q;
   logic [TAG_W-1:0] tag_q, nxt_tag_q;
   logic             hit_cpl;

   assign hit_cpl = busy_q && cq_valid && (cq_tag == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         rd_q      <= 1'b0;
         tag_q     <= '0;
         nxt_tag_q <= '0;
      end else if (rq_valid && rq_ready) begin
         busy_q    <= 1'b1;
         rd_q      <= !lb_wr;
         tag_q     <= rq_tag;
         nxt_tag_q <= rq_tag + 1'b1;
      end else if (hit_cpl && cq_pop) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
      end
   end

   // R2
   only_data_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> (lb_sel && lb_addr == D_OFF));

   // R3
   wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_ready && lb_wr) |-> lb_ready);

   // R4
   push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_addr) && $stable(rq_tag)));

   // R5
   rd_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cpl && rd_q && cq_ok) |-> (lb_ready && lb_rdata == cq_data));

   // R6
   pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cq_pop |-> cq_valid);

   // R7
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> !busy_q);

   // R8
   err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cpl && rd_q && !cq_ok) |-> (lb_ready && lb_rdata == '1));

   // R9
   lk_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_addr == D_OFF) |-> (lk_rdata == '0));

   // R10
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid |-> (rq_tag == nxt_tag_q));
endmodule

bind cfg_window_port cfg_window_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .DATA_OFF(DATA_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lb_sel(lb_sel), .lb_wr(lb_wr), .lb_addr(lb_addr),
   .lb_ready(lb_ready), .lb_rdata(lb_rdata), .rq_valid(rq_valid), .rq_ready(rq_ready),
   .rq_addr(rq_addr), .rq_tag(rq_tag), .cq_valid(cq_valid), .cq_pop(cq_pop),
   .cq_tag(cq_tag), .cq_ok(cq_ok), .cq_data(cq_data), .lk_addr(lk_addr),
   .lk_rdata(lk_rdata)
);

// File: tb/cfg_window_port_bench.sv
module cfg_window_port_bench;
   localparam logic [11:0] A_OFF = 12'h32C;
   localparam logic [11:0] D_OFF = 12'h330;
   localparam logic [11:0] S_OFF = 12'h334;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lb_sel = 1'b0, lb_wr = 1'b0;
   logic [11:0] lb_addr = '0;
   logic [31:0] lb_wdata = '0;
   logic        lb_ready;
   logic [31:0] lb_rdata;
   logic        rq_valid, rq_write;
   logic        rq_ready = 1'b0;
   logic [31:0] rq_addr, rq_data;
   logic [3:0]  rq_tag;
   logic        cq_valid = 1'b0, cq_ok = 1'b1;
   logic        cq_pop;
   logic [3:0]  cq_tag = '0;
   logic [31:0] cq_data = '0;
   logic [11:0] lk_addr = '0;
   logic [31:0] lk_rdata;

   int checks = 0;
   int failures = 0;
   logic [31:0] model_addr = '0;
   logic        model_err = 1'b0;
   logic [3:0]  exp_tag = '0;

   always #4 clk = ~clk;

   cfg_window_port u_cfg_window_port (
      .clk(clk), .rst_n(rst_n), .lb_sel(lb_sel), .lb_wr(lb_wr), .lb_addr(lb_addr),
      .lb_wdata(lb_wdata), .lb_ready(lb_ready), .lb_rdata(lb_rdata),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_write(rq_write),
      .rq_addr(rq_addr), .rq_data(rq_data), .rq_tag(rq_tag),
      .cq_valid(cq_valid), .cq_pop(cq_pop), .cq_tag(cq_tag), .cq_ok(cq_ok),
      .cq_data(cq_data), .lk_addr(lk_addr), .lk_rdata(lk_rdata)
   );

   typedef struct packed {
      logic [2:0]  op;     // 0 addr wr, 1 addr rd, 2 cfg wr, 3 cfg rd, 4 status rd
      logic [31:0] val;
      logic        ok;
      logic [31:0] cd;
      logic [1:0]  stall;
      logic        junk;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 32'h0001_0804, 1'b1, 32'h0,         2'd0, 1'b0},
      '{3'd1, 32'h0,         1'b1, 32'h0,         2'd0, 1'b0},
      '{3'd2, 32'hA5A5_0F0F, 1'b1, 32'h0,         2'd0, 1'b0},
      '{3'd3, 32'h0,         1'b1, 32'h1234_5678, 2'd2, 1'b0},
      '{3'd0, 32'h00FF_F000, 1'b1, 32'h0,         2'd0, 1'b0},
      '{3'd2, 32'hDEAD_BEEF, 1'b1, 32'h0,         2'd1, 1'b1},
      '{3'd3, 32'h0,         1'b0, 32'h5555_5555, 2'd0, 1'b1},
      '{3'd4, 32'h1,         1'b1, 32'h0,         2'd0, 1'b0}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      lb_sel = 1'b1; lb_wr = 1'b1; lb_addr = a; lb_wdata = d;
      #1;
      check(lb_ready && !rq_valid, "R2 register write completes without push",
            {30'b0, lb_ready, rq_valid}, 32'h2);
      @(negedge clk);
      lb_sel = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      lb_sel = 1'b1; lb_wr = 1'b0; lb_addr = a;
      #1;
      d = lb_ready ? lb_rdata : 32'hXXXX_XXXX;
      @(negedge clk);
      lb_sel = 1'b0;
   endtask

   task automatic bus_start(input logic wr, input logic [31:0] d);
      @(negedge clk);
      lb_sel = 1'b1; lb_wr = wr; lb_addr = D_OFF; lb_wdata = d;
   endtask

   task automatic push_phase(input logic wr, input logic [31:0] d, input int stall);
      for (int s = 0; s < stall; s++) begin
         #1;
         check(rq_valid && !lb_ready, "R4 stalled push holds bus",
               {30'b0, rq_valid, lb_ready}, 32'h2);
         @(negedge clk);
      end
      rq_ready = 1'b1;
      #1;
      check(rq_valid && rq_write == wr, "R3 push offered with direction",
            {30'b0, rq_valid, rq_write}, {30'b0, 1'b1, wr});
      check(rq_addr == model_addr, "R3 push target from address register", rq_addr, model_addr);
      check(rq_tag == exp_tag, "R10 request tag", {28'b0, rq_tag}, {28'b0, exp_tag});
      if (wr) begin
         check(rq_data == d, "R3 write data passed through", rq_data, d);
         check(lb_ready, "R3 bus released on accept", {31'b0, lb_ready}, 32'h1);
      end
      @(negedge clk);
      rq_ready = 1'b0;
      if (wr) lb_sel = 1'b0;
      else begin
         #1;
         check(!lb_ready, "R5 read held after push", {31'b0, lb_ready}, 32'h0);
      end
   endtask

   task automatic cpl_phase(input logic rd, input logic ok, input logic [31:0] cd,
                            input logic junk);
      if (junk) begin
         cq_valid = 1'b1; cq_tag = exp_tag + 4'd1; cq_ok = 1'b1; cq_data = 32'hBAD0_BAD0;
         #1;
         check(cq_pop && (!rd || !lb_ready), "R6 stray completion popped and ignored",
               {30'b0, cq_pop, lb_ready}, 32'h2);
         @(negedge clk);
      end
      cq_valid = 1'b1; cq_tag = exp_tag; cq_ok = ok; cq_data = cd;
      #1;
      check(cq_pop, "R6 matching completion popped", {31'b0, cq_pop}, 32'h1);
      if (rd) begin
         check(lb_ready, "R5 read completes on matching tag", {31'b0, lb_ready}, 32'h1);
         if (ok) check(lb_rdata == cd, "R5 read data from completion", lb_rdata, cd);
         else check(lb_rdata == 32'hFFFF_FFFF, "R8 failed read returns ones",
                    lb_rdata, 32'hFFFF_FFFF);
      end
      if (!ok) model_err = 1'b1;
      @(negedge clk);
      cq_valid = 1'b0;
      lb_sel = 1'b0;
      exp_tag = exp_tag + 4'd1;
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      #1;
      check(!rq_valid && !cq_pop, "R1 no request or pop in reset",
            {30'b0, rq_valid, cq_pop}, 32'h0);
      rst_n = 1'b1;
      reg_read(A_OFF, rd);
      check(rd == 32'h0, "R1 address register reset", rd, 32'h0);
      reg_read(S_OFF, rd);
      check(rd == 32'h0, "R1 status reset", rd, 32'h0);

      for (int i = 0; i < 8; i++) begin
         case (VECS[i].op)
            3'd0: begin
               reg_write(A_OFF, VECS[i].val);
               model_addr = VECS[i].val;
            end
            3'd1: begin
               reg_read(A_OFF, rd);
               check(rd == model_addr, "R2 address register readback", rd, model_addr);
            end
            3'd2: begin
               bus_start(1'b1, VECS[i].val);
               push_phase(1'b1, VECS[i].val, int'(VECS[i].stall));
               cpl_phase(1'b0, VECS[i].ok, VECS[i].cd, VECS[i].junk);
            end
            3'd3: begin
               bus_start(1'b0, 32'h0);
               push_phase(1'b0, 32'h0, int'(VECS[i].stall));
               cpl_phase(1'b1, VECS[i].ok, VECS[i].cd, VECS[i].junk);
            end
            default: begin
               reg_read(S_OFF, rd);
               check(rd == VECS[i].val, "R8 status after failing completion", rd, VECS[i].val);
            end
         endcase
      end

      // R8 write 0 keeps flag, write 1 clears it
      reg_write(S_OFF, 32'h0);
      reg_read(S_OFF, rd);
      check(rd == 32'h1, "R8 write of zero keeps error", rd, 32'h1);
      reg_write(S_OFF, 32'h1);
      model_err = 1'b0;
      reg_read(S_OFF, rd);
      check(rd == 32'h0, "R8 write of one clears error", rd, 32'h0);

      // R7 read launched while a write still waits for its completion
      bus_start(1'b1, 32'h0BAD_F00D);
      push_phase(1'b1, 32'h0BAD_F00D, 0);
      lb_sel = 1'b1; lb_wr = 1'b0; lb_addr = D_OFF;
      for (int k = 0; k < 2; k++) begin
         #1;
         check(!rq_valid && !lb_ready, "R7 second access waits",
               {30'b0, rq_valid, lb_ready}, 32'h0);
         @(negedge clk);
      end
      cq_valid = 1'b1; cq_tag = exp_tag; cq_ok = 1'b1; cq_data = 32'h7777_7777;
      #1;
      check(cq_pop && !lb_ready, "R7 write completion does not answer read",
            {30'b0, cq_pop, lb_ready}, 32'h2);
      @(negedge clk);
      cq_valid = 1'b0;
      exp_tag = exp_tag + 4'd1;
      push_phase(1'b0, 32'h0, 0);
      cpl_phase(1'b1, 1'b1, 32'hC0DE_0001, 1'b0);

      // R10 tag wrap over a run of writes
      for (int n = 0; n < 12; n++) begin
         reg_write(A_OFF, 32'h0100_0000 + n);
         model_addr = 32'h0100_0000 + n;
         bus_start(1'b1, 32'h5A00_0000 + n);
         push_phase(1'b1, 32'h5A00_0000 + n, n % 2);
         cpl_phase(1'b0, 1'b1, 32'h0, 1'b0);
      end

      // R9 link-side view
      lk_addr = A_OFF; #1;
      check(lk_rdata == model_addr, "R9 link view of address register", lk_rdata, model_addr);
      lk_addr = D_OFF; #1;
      check(lk_rdata == 32'h0, "R9 link view of data window", lk_rdata, 32'h0);
      lk_addr = S_OFF; #1;
      check(lk_rdata == 32'h0, "R9 link view of status", lk_rdata, 32'h0);

      // R11 unmapped offset
      reg_read(12'h100, rd);
      check(rd == 32'h0, "R11 unmapped read is zero", rd, 32'h0);

      // R1 reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_addr = '0;
      exp_tag = '0;
      reg_read(A_OFF, rd);
      check(rd == 32'h0, "R1 address register after reset", rd, 32'h0);
      bus_start(1'b0, 32'h0);
      push_phase(1'b0, 32'h0, 0);
      cpl_phase(1'b1, 1'b1, 32'h0000_ABCD, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule